// File: doc/BRIEF.md
# Pointer-Addressed Data Memory

This block is the byte-wide data store of a small microcontroller core. It keeps 128 bytes: a general area at addresses 0x00 to 0x6F and a 16-byte register window at 0xF0 to 0xFF. Three window bytes also serve as pointers. 0xFE is the primary address pointer, 0xFC is the alternate address pointer and 0xFD is the stack pointer. Because these pointers sit in the address space, they can be read, written and bit-edited like any other byte.

The core sends one command per clock on a synchronous command port. A command is an opcode, an address, a pointer select, a post-adjust code, a bit index and write data. The block returns a registered data byte and a zero flag. Indirect commands take their address from a pointer and may step that pointer by one in either direction as part of the same command. The block can also set, clear or test a single bit, and it can decrement a window register while reporting whether the result reached zero, so the core can skip its next instruction.

Top module: `dmem_ptr_unit`

## Requirements
- R1: Command 2 (direct write) stores `cmd_wdata` at `cmd_addr` and returns `rdata` = 0x00. Command 1 (direct read) returns the addressed byte. Both results appear one clock after the accepting edge. Addresses 0x00–0x6F and 0xF0–0xFF are storage, and `zflag` is 0 after either command.
- R2: Addresses 0x70–0xEF are unmapped. Reads of them return 0x00, and writes or bit set/clear (command 5 or 6) to them return 0x00 and change no stored byte.
- R3: Reset clears `rdata` and `zflag` and loads 0x6F into the stack pointer at 0xFD. The alternate pointer is at 0xFC and the primary pointer at 0xFE.
- R4: Commands 3 (indirect read) and 4 (indirect write) use the contents of the primary pointer when `cmd_ptr`=0, or of the alternate pointer when `cmd_ptr`=1, as the address.
- R5: On commands 3 and 4, `cmd_adj` 1 increments the selected pointer and `cmd_adj` 2 decrements it, modulo 256. `cmd_adj` 0 and 3 leave it unchanged. The new value is visible to the next command.
- R6: If an indirect write lands on the address of the pointer it used, the written data wins over the post-adjust.
- R7: Commands 5 (bit set) and 6 (bit clear) change only bit `cmd_bit` of the addressed byte and return the resulting byte.
- R8: Command 7 (bit test) returns the byte and sets `zflag` to 1 exactly when bit `cmd_bit` is 0. It stores nothing. An unmapped byte tests as 0x00.
- R9: Command 8 (decrement-test) on a window address stores the byte minus one (modulo 256), returns it, and sets `zflag` when it is 0x00. On any other address it returns 0x00 with `zflag` 0 and stores nothing.
- R10: Command 0 (idle) and the unused codes 9–15 keep `rdata` and `zflag` unchanged and store nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_op | input | 4 | Command code |
| cmd_addr | input | 8 | Direct address |
| cmd_ptr | input | 1 | Pointer select: 0 primary, 1 alternate |
| cmd_adj | input | 2 | Post-adjust: 1 increment, 2 decrement |
| cmd_bit | input | 3 | Bit index for bit commands |
| cmd_wdata | input | 8 | Write data |
| rdata | output | 8 | Registered result byte |
| zflag | output | 1 | Registered zero / bit-clear flag |

## Verification
Every result on `rdata` and `zflag` is registered, so it is due one clock after the rising edge that takes the command. Every store or pointer step is visible to the command accepted at the following edge. The bench applies each command at a falling edge and samples 1 ns after the next rising edge, which is exactly one register stage later. Stored effects, such as a pointer step, a suppressed adjust or an ignored write, are checked by the read command in the next row, never in the same cycle.

// File: rtl/dmem_pkg.sv
package dmem_pkg;
    localparam int DW        = 8;
    localparam int AW        = 8;
    localparam int GEN_LAST  = 'h6F;
    localparam int WIN_BASE  = 'hF0;
    localparam int WIN_DEPTH = 16;
    localparam int DEPTH     = GEN_LAST + 1 + WIN_DEPTH;
    localparam int IW        = $clog2(DEPTH);
    localparam int BW        = $clog2(DW);
    localparam int NPTR      = 2;

    localparam int ADDR_ALT  = 'hFC;
    localparam int ADDR_STK  = 'hFD;
    localparam int ADDR_PRI  = 'hFE;
    localparam int STK_RESET = 'h6F;

    function automatic int win_slot(input int a);
        return GEN_LAST + 1 + (a - WIN_BASE);
    endfunction

    localparam int IDX_ALT = win_slot(ADDR_ALT);
    localparam int IDX_STK = win_slot(ADDR_STK);
    localparam int IDX_PRI = win_slot(ADDR_PRI);

    typedef enum logic [3:0] {
        OP_IDLE = 4'd0,
        OP_RDD  = 4'd1,
        OP_WRD  = 4'd2,
        OP_RDI  = 4'd3,
        OP_WRI  = 4'd4,
        OP_BSET = 4'd5,
        OP_BCLR = 4'd6,
        OP_BTST = 4'd7,
        OP_DECT = 4'd8
    } op_e;

    typedef enum logic [1:0] {
        ADJ_NONE = 2'd0,
        ADJ_INC  = 2'd1,
        ADJ_DEC  = 2'd2,
        ADJ_KEEP = 2'd3
    } adj_e;
endpackage

// File: rtl/dmem_addr_map.sv
module dmem_addr_map #(
    parameter int AW        = dmem_pkg::AW,
    parameter int IW        = dmem_pkg::IW,
    parameter int GEN_LAST  = dmem_pkg::GEN_LAST,
    parameter int WIN_BASE  = dmem_pkg::WIN_BASE,
    parameter int WIN_DEPTH = dmem_pkg::WIN_DEPTH
) (
    input  logic [AW-1:0] addr,
    output logic          hit,
    output logic          win,
    output logic [IW-1:0] idx
);
    int a_int;
    logic in_gen;

    always_comb begin
        a_int  = int'(addr);
        in_gen = (a_int <= GEN_LAST);
        win    = (a_int >= WIN_BASE) && (a_int < WIN_BASE + WIN_DEPTH);
        hit    = in_gen || win;
        if (win) begin
            idx = IW'(GEN_LAST + 1 + a_int - WIN_BASE);
        end else if (in_gen) begin
            idx = IW'(a_int);
        end else begin
            idx = '0;
        end
    end

    // R2: an unmapped address never reports a hit
    always_comb begin
        if ((a_int > GEN_LAST) && (a_int < WIN_BASE)) begin
            a_r2_unmapped_miss: assert (!hit);
        end
    end
endmodule

// File: rtl/dmem_ptr_step.sv
module dmem_ptr_step #(
    parameter int DW = dmem_pkg::DW
) (
    input  logic [DW-1:0]     cur,
    input  dmem_pkg::adj_e    adj,
    output logic [DW-1:0]     nxt,
    output logic              moves
);
    always_comb begin
        unique case (adj)
            dmem_pkg::ADJ_INC: begin nxt = cur + DW'(1); moves = 1'b1; end
            dmem_pkg::ADJ_DEC: begin nxt = cur - DW'(1); moves = 1'b1; end
            default:           begin nxt = cur;          moves = 1'b0; end
        endcase
    end
endmodule

// File: rtl/dmem_byte_alu.sv
module dmem_byte_alu #(
    parameter int DW = dmem_pkg::DW,
    parameter int BW = dmem_pkg::BW
) (
    input  dmem_pkg::op_e  op,
    input  logic [DW-1:0]  cur,
    input  logic [DW-1:0]  wdata,
    input  logic [BW-1:0]  bsel,
    input  logic           hit,
    input  logic           win,
    output logic [DW-1:0]  nb,
    output logic           we,
    output logic [DW-1:0]  rd,
    output logic           zf,
    output logic           hold
);
    import dmem_pkg::*;
    logic [DW-1:0] mask;

    always_comb begin
        mask = DW'(1) << bsel;
        nb   = cur;
        we   = 1'b0;
        rd   = '0;
        zf   = 1'b0;
        hold = 1'b0;
        case (op)
            OP_RDD, OP_RDI: rd = cur;
            OP_WRD, OP_WRI: begin
                nb = wdata;
                we = hit;
            end
            OP_BSET: begin
                nb = cur | mask;
                we = hit;
                rd = hit ? nb : '0;
            end
            OP_BCLR: begin
                nb = cur & ~mask;
                we = hit;
                rd = hit ? nb : '0;
            end
            OP_BTST: begin
                rd = cur;
                zf = ~|(cur & mask);
            end
            OP_DECT: begin
                if (win) begin
                    nb = cur - DW'(1);
                    we = 1'b1;
                    rd = nb;
                    zf = (nb == '0);
                end
            end
            default: hold = 1'b1;
        endcase
    end

    // R9: a decrement outside the window never stores
    always_comb begin
        if (op == OP_DECT && !win) begin
            a_r9_dec_window_only: assert (!we);
        end
    end
endmodule

// File: rtl/dmem_ptr_unit.sv
module dmem_ptr_unit #(
    parameter int DW = dmem_pkg::DW,
    parameter int AW = dmem_pkg::AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [3:0]    cmd_op,
    input  logic [AW-1:0] cmd_addr,
    input  logic          cmd_ptr,
    input  logic [1:0]    cmd_adj,
    input  logic [2:0]    cmd_bit,
    input  logic [DW-1:0] cmd_wdata,
    output logic [DW-1:0] rdata,
    output logic          zflag
);
    import dmem_pkg::*;

    localparam int PTR_IDX [NPTR] = '{IDX_PRI, IDX_ALT};

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [DW-1:0]            rdata;
        logic                     zflag;
    } state_t;

    state_t st_d, st_q;

    op_e            op;
    adj_e           adj;
    logic           is_ind;
    logic [DW-1:0]  ptr_now   [NPTR];
    logic [DW-1:0]  ptr_next  [NPTR];
    logic [NPTR-1:0] ptr_moves;
    logic [AW-1:0]  eff_addr;
    logic           map_hit, map_win;
    logic [IW-1:0]  map_idx, sel_idx;
    logic [DW-1:0]  cur_byte;
    logic [DW-1:0]  alu_nb, alu_rd;
    logic           alu_we, alu_zf, alu_hold;
    logic [DW-1:0]  ptr_pri, ptr_alt, ptr_stk;

    assign op       = op_e'(cmd_op);
    assign adj      = adj_e'(cmd_adj);
    assign is_ind   = (op == OP_RDI) || (op == OP_WRI);
    assign eff_addr = is_ind ? AW'(ptr_now[cmd_ptr]) : cmd_addr;
    assign sel_idx  = cmd_ptr ? IW'(IDX_ALT) : IW'(IDX_PRI);
    assign cur_byte = map_hit ? st_q.mem[map_idx] : '0;
    assign ptr_pri  = st_q.mem[IDX_PRI];
    assign ptr_alt  = st_q.mem[IDX_ALT];
    assign ptr_stk  = st_q.mem[IDX_STK];

    for (genvar g = 0; g < NPTR; g++) begin : g_ptr
        assign ptr_now[g] = st_q.mem[PTR_IDX[g]];
        dmem_ptr_step #(.DW(DW)) u_step (
            .cur   (ptr_now[g]),
            .adj   (adj),
            .nxt   (ptr_next[g]),
            .moves (ptr_moves[g])
        );
    end

    dmem_addr_map #(.AW(AW), .IW(IW)) u_map (
        .addr (eff_addr),
        .hit  (map_hit),
        .win  (map_win),
        .idx  (map_idx)
    );

    dmem_byte_alu #(.DW(DW), .BW(BW)) u_alu (
        .op    (op),
        .cur   (cur_byte),
        .wdata (cmd_wdata),
        .bsel  (BW'(cmd_bit)),
        .hit   (map_hit),
        .win   (map_win),
        .nb    (alu_nb),
        .we    (alu_we),
        .rd    (alu_rd),
        .zf    (alu_zf),
        .hold  (alu_hold)
    );

    always_comb begin
        st_d = st_q;
        if (!alu_hold) begin
            st_d.rdata = alu_rd;
            st_d.zflag = alu_zf;
        end
        if (alu_we && map_hit) begin
            st_d.mem[map_idx] = alu_nb;
        end
        if (is_ind && ptr_moves[cmd_ptr]
            && !(alu_we && map_hit && (map_idx == sel_idx))) begin
            st_d.mem[sel_idx] = ptr_next[cmd_ptr];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.rdata        <= '0;
            st_q.zflag        <= 1'b0;
            st_q.mem[IDX_STK] <= DW'(STK_RESET);
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata = st_q.rdata;
    assign zflag = st_q.zflag;

    // R3: stack pointer holds its reset value after reset
    a_r3_stack_reset: assert property (@(posedge clk)
        !rst_n |=> ptr_stk == DW'(STK_RESET));

    // R2: direct read of an unmapped address yields zero
    a_r2_unmapped_read: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_RDD && !map_hit) |=> rdata == '0);

    // R5: indirect read with increment steps the primary pointer by one
    a_r5_pri_increment: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_RDI && adj == ADJ_INC && !cmd_ptr) |=> ptr_pri == $past(ptr_pri) + DW'(1));

    // R6: write onto the used pointer beats the post-adjust
    a_r6_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_WRI && cmd_ptr && adj == ADJ_DEC && ptr_alt == DW'(ADDR_ALT))
        |=> ptr_alt == $past(cmd_wdata));

    // R7: a set on a mapped byte returns that bit high
    a_r7_bit_set: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_BSET && map_hit) |=> rdata[$past(cmd_bit)] == 1'b1);

    // R9: decrementing a window byte of one flags zero
    a_r9_dec_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_DECT && map_win && cur_byte == DW'(1)) |=> (zflag && rdata == '0));

    // R10: idle leaves both outputs unchanged
    a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == 4'd0) |=> ($stable(rdata) && $stable(zflag)));
endmodule

// File: tb/dmem_ptr_unit_tb.sv
module dmem_ptr_unit_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] cmd_op = '0;
    logic [7:0] cmd_addr = '0;
    logic       cmd_ptr = 1'b0;
    logic [1:0] cmd_adj = '0;
    logic [2:0] cmd_bit = '0;
    logic [7:0] cmd_wdata = '0;
    logic [7:0] rdata;
    logic       zflag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dmem_ptr_unit u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
        .cmd_ptr(cmd_ptr), .cmd_adj(cmd_adj), .cmd_bit(cmd_bit),
        .cmd_wdata(cmd_wdata), .rdata(rdata), .zflag(zflag)
    );

    typedef struct packed {
        logic [3:0] op;
        logic [7:0] addr;
        logic       ptr;
        logic [1:0] adj;
        logic [2:0] bsel;
        logic [7:0] wd;
        logic [7:0] exp;
        logic       ez;
        logic [3:0] req;
    } vec_t;

    function automatic vec_t mk(input logic [3:0] op, input logic [7:0] addr,
                                input logic ptr, input logic [1:0] adj,
                                input logic [2:0] bsel, input logic [7:0] wd,
                                input logic [7:0] exp, input logic ez,
                                input logic [3:0] req);
        return '{op, addr, ptr, adj, bsel, wd, exp, ez, req};
    endfunction

    localparam int N = 60;
    localparam vec_t VEC [N] = '{
        mk(1, 8'hFD, 0, 0, 0, 8'h00, 8'h6F, 0, 3),  // R3 stack reset
        mk(2, 8'h10, 0, 0, 0, 8'hA5, 8'h00, 0, 1),  // R1
        mk(1, 8'h10, 0, 0, 0, 8'h00, 8'hA5, 0, 1),
        mk(2, 8'hF3, 0, 0, 0, 8'h3C, 8'h00, 0, 1),
        mk(1, 8'hF3, 0, 0, 0, 8'h00, 8'h3C, 0, 1),
        mk(2, 8'h6F, 0, 0, 0, 8'h81, 8'h00, 0, 1),
        mk(1, 8'h6F, 0, 0, 0, 8'h00, 8'h81, 0, 1),
        mk(2, 8'hF0, 0, 0, 0, 8'h11, 8'h00, 0, 2),  // R2
        mk(2, 8'h70, 0, 0, 0, 8'h55, 8'h00, 0, 2),
        mk(1, 8'h70, 0, 0, 0, 8'h00, 8'h00, 0, 2),
        mk(1, 8'hEF, 0, 0, 0, 8'h00, 8'h00, 0, 2),
        mk(1, 8'hF0, 0, 0, 0, 8'h00, 8'h11, 0, 2),
        mk(2, 8'hFE, 0, 0, 0, 8'h10, 8'h00, 0, 4),  // R4
        mk(3, 8'h00, 0, 0, 0, 8'h00, 8'hA5, 0, 4),
        mk(1, 8'hFE, 0, 0, 0, 8'h00, 8'h10, 0, 5),  // R5
        mk(2, 8'h11, 0, 0, 0, 8'h77, 8'h00, 0, 5),
        mk(3, 8'h00, 0, 1, 0, 8'h00, 8'hA5, 0, 5),
        mk(1, 8'hFE, 0, 0, 0, 8'h00, 8'h11, 0, 5),
        mk(3, 8'h00, 0, 0, 0, 8'h00, 8'h77, 0, 4),
        mk(2, 8'hFC, 0, 0, 0, 8'hF3, 8'h00, 0, 4),
        mk(4, 8'h00, 1, 2, 0, 8'h99, 8'h00, 0, 4),
        mk(1, 8'hFC, 0, 0, 0, 8'h00, 8'hF2, 0, 5),
        mk(1, 8'hF3, 0, 0, 0, 8'h00, 8'h99, 0, 4),
        mk(2, 8'h00, 0, 0, 0, 8'h42, 8'h00, 0, 5),
        mk(2, 8'hFF, 0, 0, 0, 8'h5A, 8'h00, 0, 5),
        mk(2, 8'hFC, 0, 0, 0, 8'h00, 8'h00, 0, 5),
        mk(3, 8'h00, 1, 2, 0, 8'h00, 8'h42, 0, 5),
        mk(1, 8'hFC, 0, 0, 0, 8'h00, 8'hFF, 0, 5),
        mk(3, 8'h00, 1, 1, 0, 8'h00, 8'h5A, 0, 5),
        mk(1, 8'hFC, 0, 0, 0, 8'h00, 8'h00, 0, 5),
        mk(3, 8'h00, 1, 3, 0, 8'h00, 8'h42, 0, 5),
        mk(1, 8'hFC, 0, 0, 0, 8'h00, 8'h00, 0, 5),
        mk(2, 8'hFE, 0, 0, 0, 8'hFE, 8'h00, 0, 6),  // R6
        mk(4, 8'h00, 0, 1, 0, 8'h20, 8'h00, 0, 6),
        mk(1, 8'hFE, 0, 0, 0, 8'h00, 8'h20, 0, 6),
        mk(2, 8'hFC, 0, 0, 0, 8'hFC, 8'h00, 0, 6),
        mk(4, 8'h00, 1, 2, 0, 8'h33, 8'h00, 0, 6),
        mk(1, 8'hFC, 0, 0, 0, 8'h00, 8'h33, 0, 6),
        mk(2, 8'h20, 0, 0, 0, 8'h00, 8'h00, 0, 7),  // R7
        mk(5, 8'h20, 0, 0, 7, 8'h00, 8'h80, 0, 7),
        mk(5, 8'h20, 0, 0, 0, 8'h00, 8'h81, 0, 7),
        mk(6, 8'h20, 0, 0, 7, 8'h00, 8'h01, 0, 7),
        mk(1, 8'h20, 0, 0, 0, 8'h00, 8'h01, 0, 7),
        mk(2, 8'hF5, 0, 0, 0, 8'hF0, 8'h00, 0, 7),
        mk(5, 8'hF5, 0, 0, 3, 8'h00, 8'hF8, 0, 7),
        mk(7, 8'h20, 0, 0, 0, 8'h00, 8'h01, 0, 8),  // R8
        mk(7, 8'h20, 0, 0, 1, 8'h00, 8'h01, 1, 8),
        mk(1, 8'h20, 0, 0, 0, 8'h00, 8'h01, 0, 8),
        mk(7, 8'h80, 0, 0, 0, 8'h00, 8'h00, 1, 8),
        mk(2, 8'hF8, 0, 0, 0, 8'h02, 8'h00, 0, 9),  // R9
        mk(8, 8'hF8, 0, 0, 0, 8'h00, 8'h01, 0, 9),
        mk(8, 8'hF8, 0, 0, 0, 8'h00, 8'h00, 1, 9),
        mk(0, 8'hF8, 0, 0, 0, 8'h00, 8'h00, 1, 10), // R10
        mk(15, 8'hF8, 0, 0, 0, 8'h00, 8'h00, 1, 10),
        mk(8, 8'hF8, 0, 0, 0, 8'h00, 8'hFF, 0, 9),
        mk(8, 8'h20, 0, 0, 0, 8'h00, 8'h00, 0, 9),
        mk(1, 8'h20, 0, 0, 0, 8'h00, 8'h01, 0, 9),
        mk(5, 8'h90, 0, 0, 2, 8'h00, 8'h00, 0, 2),
        mk(8, 8'h6F, 0, 0, 0, 8'h00, 8'h00, 0, 9),
        mk(1, 8'h6F, 0, 0, 0, 8'h00, 8'h81, 0, 9)
    };

    task automatic check(input logic [7:0] exp, input logic ez, input int req);
        checks++;
        if (rdata !== exp || zflag !== ez) begin
            errors++;
            $display("FAIL R%0d rdata=%02h zflag=%0b expected rdata=%02h zflag=%0b",
                     req, rdata, zflag, exp, ez);
        end
    endtask

    task automatic issue(input vec_t v);
        @(negedge clk);
        cmd_op = v.op; cmd_addr = v.addr; cmd_ptr = v.ptr; cmd_adj = v.adj;
        cmd_bit = v.bsel; cmd_wdata = v.wd;
        @(posedge clk);
        #1;
        check(v.exp, v.ez, int'(v.req));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check(8'h00, 1'b0, 3);  // R3 outputs cleared by reset

        for (int i = 0; i < N; i++) begin
            issue(VEC[i]);
        end

        // R3: stack pointer reloads on a later reset
        issue(mk(2, 8'hFD, 0, 0, 0, 8'h30, 8'h00, 0, 3));
        issue(mk(1, 8'hFD, 0, 0, 0, 8'h00, 8'h30, 0, 3));
        @(negedge clk);
        cmd_op = 4'd0;
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check(8'h00, 1'b0, 3);
        issue(mk(1, 8'hFD, 0, 0, 0, 8'h00, 8'h6F, 0, 3));

        @(negedge clk);
        cmd_op = 4'd0;
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired rdata=%02h expected completion", rdata);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule